// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel clock signals for a parallel TFT panel, along with the column and row of the pixel currently being shown. A pixel source can use those coordinates to fetch its data. The pixel rate comes from an integer division of the core clock. Every output is generated in the core clock domain.

Software describes the panel through one control word and three packed timing words. Most fields are stored as the value minus one. The vertical porches are stored as plain counts. Several fields are split between two words, and the active width is given in steps of 16 pixels. The block unpacks these fields into shadow registers. The shadow registers reload only while the raster is stopped or at the end of a frame, so a frame never mixes two timing sets.

Inside each line the phases run in this order: sync, back porch, active, front porch. A frame runs through the same four phases, counted in lines. Polarity bits can invert any output. The sync outputs can also be launched half a pixel period late, on the falling edge of the pixel clock.

Top module: `lcd_raster_timer`

## Requirements
- R1: In `ctrl_word`, bit 0 is the raster enable and bits 15:8 hold the divisor D. A divisor of 0 or 1 acts as 2. Each pixel lasts D core cycles. The uninverted pixel clock is high for the first floor(D/2) cycles of each pixel and low for the rest.
- R2: In `htime_word`, bits 9:4 hold width/16-1 and bit 3 holds bit 10 of width-1, so the width is a multiple of 16 up to 2048. Bits 15:10 hold the low 6 bits of hsync-1, bits 23:16 the low 8 bits of front porch-1, and bits 31:24 the low 8 bits of back porch-1.
- R3: In `xtime_word`, bits 1:0 hold bits 9:8 of horizontal front porch-1, bits 5:4 hold bits 9:8 of horizontal back porch-1, and bits 30:27 hold bits 9:6 of hsync width-1. Each horizontal porch and the hsync width are therefore 1 to 1024 pixels.
- R4: In `vtime_word`, bits 9:0 hold the low bits of lines-1, and `xtime_word` bit 26 holds bit 10 of lines-1. `vtime_word` bits 15:10 hold vsync-1. Bits 23:16 hold the vertical front porch and bits 31:24 the vertical back porch, both as plain line counts. A porch count of zero removes that phase from the frame.
- R5: Each line runs sync, back porch, active, front porch, counted in pixels. Each frame runs the same four phases, counted in lines. Hsync is asserted during the line sync phase and vsync during every line of the frame sync phase.
- R6: Data enable is asserted only when both the line and the frame are in their active phase. `pix_x` and `pix_y` then count from 0 across the active pixels and lines, and both read 0 whenever data enable is inactive.
- R7: `xtime_word` bits 20, 21, 22 and 23 invert vsync, hsync, the pixel clock and data enable respectively.
- R8: When `xtime_word` bits 25 and 24 are both 1, hsync and vsync change floor(D/2) core cycles after the pixel boundary, at the falling edge of the pixel clock. In every other case they change together with data enable.
- R9: One cycle after the enable is sampled low, every output is at its inactive level and all counters return to the start of the sync phase. Pixel 0 of a new frame occupies the first D cycles after the clock edge that samples the enable high.
- R10: All timing fields, the divisor and the polarity bits take effect only at the start of a frame. A change written in the middle of a frame leaves the rest of that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Enable and pixel clock divisor |
| htime_word | input | 32 | Width, hsync width and low bits of the horizontal porches |
| vtime_word | input | 32 | Line count, vsync width and vertical porches |
| xtime_word | input | 32 | High bits of split fields, polarity bits and sync launch bits |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x | output | 11 | Active column, 0 outside active |
| pix_y | output | 11 | Active row, 0 outside active |

## Verification
The bench predicts every output on every core cycle and goes after the corner cases where this block is easiest to get wrong. One case sets both vertical porches to zero; a design that enters an empty porch phase anyway would add a blank line or wrap its counter over 256 lines. Other cases place a set bit in the width MSB, in the upper hsync bits, in the high porch bits and in the line-count MSB; dropping any of those would shorten a line or a frame by hundreds of units. The bench also changes the configuration in the middle of a frame, where a design without shadow registers would bend the current frame. It uses a divisor of 0, which must act as 2, and the late sync launch, where a half-period slip would put the syncs a few cycles off. Finally it clears the enable in the middle of a frame; a design that kept its counters would restart in the wrong phase.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] htime_word,
  input  logic [31:0] vtime_word,
  input  logic [31:0] xtime_word,
  output logic        pclk_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic [10:0] pix_x,
  output logic [10:0] pix_y
);

  typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACT, PH_FRONT} phase_t;

  logic        run;
  logic [7:0]  sh_div;
  logic [6:0]  sh_wid;
  logic [9:0]  sh_hsw, sh_hbp, sh_hfp;
  logic [5:0]  sh_vsw;
  logic [7:0]  sh_vbp, sh_vfp;
  logic [10:0] sh_lin;
  logic [5:0]  sh_pol;

  logic [7:0]  div_cnt, div_eff, half;
  logic [10:0] hcnt, vcnt, h_end, v_end;
  phase_t      hph, vph, vph_next;
  logic        h_last, v_last, pix_tick, line_end, frame_end;
  logic        hs_int, vs_int, de_int, hs_late, vs_late, late_sel;

  logic unused_bits;
  assign unused_bits = ^{ctrl_word[31:16], ctrl_word[7:1], htime_word[2:0],
                         xtime_word[3:2], xtime_word[19:6], xtime_word[31]};

  assign div_eff = (sh_div < 8'd2) ? 8'd2 : sh_div;
  assign half    = {1'b0, div_eff[7:1]};

  always_comb begin
    case (hph)
      PH_SYNC:  h_end = {1'b0, sh_hsw};
      PH_BACK:  h_end = {1'b0, sh_hbp};
      PH_ACT:   h_end = {sh_wid, 4'hF};
      default:  h_end = {1'b0, sh_hfp};
    endcase
    case (vph)
      PH_SYNC:  v_end = {5'd0, sh_vsw};
      PH_BACK:  v_end = {3'd0, sh_vbp} - 11'd1;
      PH_ACT:   v_end = sh_lin;
      default:  v_end = {3'd0, sh_vfp} - 11'd1;
    endcase
    case (vph)
      PH_SYNC:  vph_next = (sh_vbp != 8'd0) ? PH_BACK : PH_ACT;
      PH_BACK:  vph_next = PH_ACT;
      PH_ACT:   vph_next = (sh_vfp != 8'd0) ? PH_FRONT : PH_SYNC;
      default:  vph_next = PH_SYNC;
    endcase
  end

  assign h_last    = (hcnt == h_end);
  assign v_last    = (vcnt == v_end);
  assign pix_tick  = run && (div_cnt == div_eff - 8'd1);
  assign line_end  = pix_tick && (hph == PH_FRONT) && h_last;
  assign frame_end = line_end && v_last && (vph_next == PH_SYNC);

  assign hs_int = run && (hph == PH_SYNC);
  assign vs_int = run && (vph == PH_SYNC);
  assign de_int = run && (hph == PH_ACT) && (vph == PH_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      sh_div <= '0; sh_wid <= '0; sh_hsw <= '0; sh_hbp <= '0; sh_hfp <= '0;
      sh_vsw <= '0; sh_vbp <= '0; sh_vfp <= '0; sh_lin <= '0; sh_pol <= '0;
    end else begin
      run <= ctrl_word[0];
      if (!run || frame_end) begin
        sh_div <= ctrl_word[15:8];
        sh_wid <= {htime_word[3], htime_word[9:4]};
        sh_hsw <= {xtime_word[30:27], htime_word[15:10]};
        sh_hbp <= {xtime_word[5:4], htime_word[31:24]};
        sh_hfp <= {xtime_word[1:0], htime_word[23:16]};
        sh_vsw <= vtime_word[15:10];
        sh_vfp <= vtime_word[23:16];
        sh_vbp <= vtime_word[31:24];
        sh_lin <= {xtime_word[26], vtime_word[9:0]};
        sh_pol <= xtime_word[25:20];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_word[0]) begin
      div_cnt <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
      hph     <= PH_SYNC;
      vph     <= PH_SYNC;
      hs_late <= 1'b0;
      vs_late <= 1'b0;
    end else if (run) begin
      div_cnt <= pix_tick ? 8'd0 : div_cnt + 8'd1;
      if (div_cnt == half - 8'd1) begin
        hs_late <= hs_int;
        vs_late <= vs_int;
      end
      if (pix_tick) begin
        if (h_last) begin
          hcnt <= '0;
          hph  <= phase_t'(hph + 2'd1);
        end else begin
          hcnt <= hcnt + 11'd1;
        end
        if (line_end) begin
          if (v_last) begin
            vcnt <= '0;
            vph  <= vph_next;
          end else begin
            vcnt <= vcnt + 11'd1;
          end
        end
      end
    end
  end

  assign late_sel = sh_pol[5] & sh_pol[4];
  assign pclk_o   = (run && (div_cnt < half)) ^ sh_pol[2];
  assign hsync_o  = (late_sel ? hs_late : hs_int) ^ sh_pol[1];
  assign vsync_o  = (late_sel ? vs_late : vs_int) ^ sh_pol[0];
  assign de_o     = de_int ^ sh_pol[3];
  assign pix_x    = de_int ? hcnt : 11'd0;
  assign pix_y    = de_int ? vcnt : 11'd0;

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[0] |=> (!de_int && hph == PH_SYNC && vph == PH_SYNC && hcnt == 11'd0 && vcnt == 11'd0));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> $stable({sh_div, sh_wid, sh_hsw, sh_hbp, sh_hfp, sh_vsw, sh_vbp, sh_vfp, sh_lin, sh_pol}));

  // R1
  pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_word[0] && !pix_tick) |=> ($stable(hcnt) && $stable(hph) && $stable(vcnt)));

  // R5
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt <= h_end));

  // R6
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[0] && pix_tick && de_int && pix_x != {sh_wid, 4'hF}) |=> (pix_x == 11'($past(pix_x) + 11'd1)));

  // R6
  de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_int |-> (!hs_int && !vs_int));

endmodule

// File: tb/lcd_raster_timer_test.sv
`timescale 1ns/1ps
module lcd_raster_timer_test;

  typedef struct {
    int w, hsw, hbp, hfp, ln, vsw, vbp, vfp, dv;
    bit vi, hi, pi, di, ed, sc;
  } cfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_w = '0, ht_w = '0, vt_w = '0, xt_w = '0;
  logic        pclk_o, hsync_o, vsync_o, de_o;
  logic [10:0] pix_x, pix_y;

  int checks = 0, failures = 0;
  cfg_t cur, P;
  bit en = 1'b0;
  int t = 0;
  bit last_hs = 1'b0, last_vs = 1'b0;

  always #2 clk = ~clk;

  lcd_raster_timer uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_w), .htime_word(ht_w),
    .vtime_word(vt_w), .xtime_word(xt_w), .pclk_o(pclk_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y));

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s t=%0d got %0d exp %0d", tag, what, t, got, exp);
    end
  endtask

  task automatic drive();
    int wm1, hm1, bm1, fm1, lm1;
    wm1 = cur.w - 1; hm1 = cur.hsw - 1; bm1 = cur.hbp - 1; fm1 = cur.hfp - 1; lm1 = cur.ln - 1;
    ctrl_w = {16'd0, 8'(cur.dv), 7'd0, en};
    ht_w = {8'(bm1), 8'(fm1), 6'(hm1), 6'(cur.w / 16 - 1), 1'(wm1 >> 10), 3'd0};
    vt_w = {8'(cur.vbp), 8'(cur.vfp), 6'(cur.vsw - 1), 10'(lm1)};
    xt_w = {1'b0, 4'(hm1 >> 6), 1'(lm1 >> 10), cur.sc, cur.ed, cur.di, cur.pi, cur.hi, cur.vi,
            14'd0, 2'(bm1 >> 8), 2'd0, 2'(fm1 >> 8)};
  endtask

  task automatic run_cycles(int n, string tag);
    int d, half, ht, vt, p, r, line, col, x, y;
    bit hs, vs, de, ehs, evs;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (t == 0) P = cur;
      d = (P.dv < 2) ? 2 : P.dv;
      half = d / 2;
      ht = P.hsw + P.hbp + P.w + P.hfp;
      vt = P.vsw + P.vbp + P.ln + P.vfp;
      p = t / d; r = t % d;
      line = p / ht; col = p % ht;
      hs = (col < P.hsw);
      vs = (line < P.vsw);
      de = (col >= P.hsw + P.hbp) && (col < P.hsw + P.hbp + P.w) &&
           (line >= P.vsw + P.vbp) && (line < P.vsw + P.vbp + P.ln);
      x = de ? col - P.hsw - P.hbp : 0;
      y = de ? line - P.vsw - P.vbp : 0;
      ehs = (P.sc && P.ed && r < half) ? last_hs : hs;
      evs = (P.sc && P.ed && r < half) ? last_vs : vs;
      chk(pclk_o == ((r < half) ^ P.pi), {tag, " R1"}, "pclk", pclk_o, (r < half) ^ P.pi);
      chk(hsync_o == (ehs ^ P.hi), {tag, " R5 R8"}, "hsync", hsync_o, ehs ^ P.hi);
      chk(vsync_o == (evs ^ P.vi), {tag, " R5 R8"}, "vsync", vsync_o, evs ^ P.vi);
      chk(de_o == (de ^ P.di), {tag, " R6"}, "de", de_o, de ^ P.di);
      chk(int'(pix_x) == x, {tag, " R6"}, "x", pix_x, x);
      chk(int'(pix_y) == y, {tag, " R6"}, "y", pix_y, y);
      if (r == d - 1) begin last_hs = hs; last_vs = vs; end
      t++;
      if (t == ht * vt * d) t = 0;
    end
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(pclk_o == cur.pi, "R9", "idle pclk", pclk_o, cur.pi);
      chk(hsync_o == cur.hi, "R9", "idle hsync", hsync_o, cur.hi);
      chk(vsync_o == cur.vi, "R9", "idle vsync", vsync_o, cur.vi);
      chk(de_o == cur.di, "R9", "idle de", de_o, cur.di);
      chk(pix_x == 11'd0 && pix_y == 11'd0, "R9", "idle xy", pix_x + pix_y, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got %0d exp %0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // base frame, zero vertical front porch (R4)
    cur = '{w:32, hsw:2, hbp:3, hfp:2, ln:3, vsw:1, vbp:1, vfp:0, dv:2,
            vi:0, hi:0, pi:0, di:0, ed:0, sc:0};
    en = 1'b0; drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_check(3);
    en = 1'b1; drive();
    t = 0; last_hs = 0; last_vs = 0;
    run_cycles(880, "R2 R4");
    // mid-frame change: inverted outputs, late sync, minimum porches (R7 R8 R10)
    cur = '{w:16, hsw:1, hbp:1, hfp:1, ln:2, vsw:2, vbp:0, vfp:2, dv:3,
            vi:1, hi:1, pi:1, di:1, ed:1, sc:1};
    drive();
    run_cycles(1000, "R7 R8 R10");
    // sync control without falling edge, divisor 0 acts as 2 (R1 R8)
    cur.ed = 0; cur.dv = 0;
    drive();
    run_cycles(700, "R1 R8 R10");
    // stop mid-frame (R9)
    en = 1'b0; drive();
    idle_check(4);
    // wide line with split high bits set (R2 R3)
    cur = '{w:1040, hsw:65, hbp:300, hfp:257, ln:1, vsw:1, vbp:0, vfp:0, dv:2,
            vi:0, hi:0, pi:0, di:0, ed:1, sc:0};
    en = 1'b1; drive();
    t = 0; last_hs = 0; last_vs = 0;
    run_cycles(7000, "R2 R3 R9");
    // tall frame with line-count MSB set (R4), written mid-frame (R10)
    cur = '{w:16, hsw:1, hbp:1, hfp:1, ln:1025, vsw:1, vbp:0, vfp:0, dv:2,
            vi:0, hi:0, pi:0, di:0, ed:0, sc:0};
    drive();
    run_cycles(6648 + 39200, "R4 R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule